// File: doc/BRIEF.md
# UART FIFO Control with Threshold Interrupts

This block buffers characters in both directions of a UART. A receive FIFO takes characters from the deserializer and hands them to the host. A transmit FIFO takes characters from the host and hands them to the serializer. Each FIFO holds 32 characters of 8 bits. Every character port is a valid/ready pair.

An 8-bit control register is written over a simple host register port. The register does three things:
- It switches both FIFOs between 32-entry mode and single-character holding mode.
- It empties either FIFO through a reset bit that clears itself.
- It selects one fill threshold for each direction.

The block drives two registered interrupts from those thresholds:
- A receive-ready interrupt that is high once enough characters are waiting.
- A transmit-empty interrupt that is high while the transmit FIFO has fallen below its threshold.

A sticky flag records any received character that was lost because the receive FIFO was full.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After synchronous reset the control register reads 0x00. Both FIFOs are empty. The receive interrupt is 0, the transmit interrupt is 1, the overrun flag is 0 and the transmit push ready is 1.
- R2: Control bit 0 enables the FIFOs and reads back as written. With a 1 each FIFO holds up to 32 characters. With a 0 each FIFO holds one character.
- R3: Writing a control word with bit 1 set empties the receive FIFO and clears the overrun flag. Bit 1 always reads back as 0.
- R4: Writing a control word with bit 2 set empties the transmit FIFO. Bit 2 always reads back as 0.
- R5: Control bit 3 reads as 0 whatever is written to it.
- R6: Control bits 7:6 select the receive threshold: 00 selects 8, 01 selects 16, 10 selects 24 and 11 selects 28. In 32-entry mode the receive interrupt is high while the receive count is at or above the threshold. In holding mode the threshold is 1.
- R7: Control bits 5:4 select the transmit threshold with the same encoding as R6. The transmit interrupt is high while the transmit count is below the threshold. In holding mode the threshold is 1, so the interrupt is high while the FIFO is empty.
- R8: Each FIFO returns characters in the order they were pushed.
- R9: A receive push while the receive FIFO is full is dropped and sets a sticky overrun flag.
- R10: While the transmit FIFO is full, the transmit push ready is low and further pushes are not stored.
- R11: A FIFO reset in the same cycle as a push or pop wins, and the FIFO is empty afterwards.
- R12: Each interrupt changes one clock cycle after the count or threshold change that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| rx_in_valid | input | 1 | Character from the deserializer |
| rx_in_data | input | 8 | Received character |
| rx_out_valid | output | 1 | Receive FIFO not empty |
| rx_out_data | output | 8 | Oldest received character |
| rx_out_ready | input | 1 | Host pops the receive FIFO |
| tx_in_valid | input | 1 | Host pushes a character to transmit |
| tx_in_data | input | 8 | Character to transmit |
| tx_in_ready | output | 1 | Transmit FIFO has room |
| tx_out_valid | output | 1 | Transmit FIFO not empty |
| tx_out_data | output | 8 | Oldest character to transmit |
| tx_out_ready | input | 1 | Serializer pops the transmit FIFO |
| rx_overrun | output | 1 | Sticky flag: a receive character was lost |
| irq_rx_ready | output | 1 | Receive threshold reached |
| irq_tx_empty | output | 1 | Transmit count below threshold |

## Verification
The bench sets each threshold code and fills both FIFOs to one below the threshold and to exactly the threshold. A design that decodes the threshold wrongly, or uses the wrong comparison (greater-or-equal against strictly-less), fails at those edges. It also catches one that swaps the receive and transmit fields.

Several other cases are driven directly:
- Characters pushed past a full FIFO. A design that overwrote or kept the extra character would return the wrong data or drop the overrun flag.
- A clear that arrives together with a push. A design that lets the push win would show a non-empty FIFO.
- Holding mode. A design that ignored the enable bit would accept a second character.
- The exact cycle an interrupt rises. A design whose interrupts were combinational would show the interrupt one cycle too early.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 32;

    // Positions inside the control word; these decode directly into actions.
    localparam int CB_ENABLE  = 0;
    localparam int CB_RX_CLR  = 1;
    localparam int CB_TX_CLR  = 2;

    typedef struct packed {
        logic [1:0] rx_sel;
        logic [1:0] tx_sel;
        logic       en;
    } fifo_cfg_t;

    // Threshold for a 2-bit code, scaled to the FIFO depth.
    function automatic int level_of(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return depth / 4;
            2'd1:    return depth / 2;
            2'd2:    return (3 * depth) / 4;
            default: return depth - depth / 8;
        endcase
    endfunction

    function automatic logic [7:0] cfg_to_word(input fifo_cfg_t c);
        return {c.rx_sel, c.tx_sel, 3'b000, c.en};
    endfunction

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    output fifo_cfg_t  cfg,
    output logic       rx_clr,
    output logic       tx_clr,
    output logic [7:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            cfg.en     <= wdata[CB_ENABLE];
            cfg.tx_sel <= wdata[5:4];
            cfg.rx_sel <= wdata[7:6];
        end
    end

    // Reset bits act on the write cycle only and are never stored.
    assign rx_clr = wr & wdata[CB_RX_CLR];
    assign tx_clr = wr & wdata[CB_TX_CLR];
    assign rdata  = cfg_to_word(cfg);

    assert_enable_follows_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr |=> (rdata[0] == $past(wdata[0])));

    assert_selects_follow_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr |=> (rdata[7:4] == $past(wdata[7:4])));

endmodule

// File: rtl/uart_char_fifo.sv
module uart_char_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [CNT_W-1:0]  cap,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    input  logic              pop_ready,
    output logic [CNT_W-1:0]  count
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              push_ok, pop_ok;

    assign push_ready = (count < cap);
    assign pop_valid  = (count != '0);
    assign pop_data   = mem[rd_ptr];
    assign push_ok    = push_valid & push_ready;
    assign pop_ok     = pop_ready & pop_valid;

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

    assert_full_refuses_R10: assert property (@(posedge clk) disable iff (rst)
        (push_valid && count >= cap && !pop_ready && !clr) |=> (count == $past(count)));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] tx_level,
    output logic             irq_rx,
    output logic             irq_tx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_rx <= 1'b0;
            irq_tx <= 1'b1;
        end else begin
            irq_rx <= (rx_count >= rx_level);
            irq_tx <= (tx_count <  tx_level);
        end
    end

    // Thresholds are never below 1, so an empty FIFO fixes both outputs.
    assert_rx_quiet_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |=> !irq_rx);

    assert_tx_raised_when_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_count == '0) |=> irq_tx);

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = FIFO_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          rx_in_valid,
    input  logic [DW-1:0] rx_in_data,
    output logic          rx_out_valid,
    output logic [DW-1:0] rx_out_data,
    input  logic          rx_out_ready,
    input  logic          tx_in_valid,
    input  logic [DW-1:0] tx_in_data,
    output logic          tx_in_ready,
    output logic          tx_out_valid,
    output logic [DW-1:0] tx_out_data,
    input  logic          tx_out_ready,
    output logic          rx_overrun,
    output logic          irq_rx_ready,
    output logic          irq_tx_empty
);

    fifo_cfg_t        cfg;
    logic             rx_clr, tx_clr, rx_room;
    logic [CNT_W-1:0] cap, rx_level, tx_level, rx_count, tx_count;

    uart_fifo_cfg u_cfg (
        .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
        .cfg(cfg), .rx_clr(rx_clr), .tx_clr(tx_clr), .rdata(reg_rdata)
    );

    // Holding mode shrinks both capacity and threshold to one character.
    assign cap      = cfg.en ? CNT_W'(DEPTH) : CNT_W'(1);
    assign rx_level = cfg.en ? CNT_W'(level_of(cfg.rx_sel, DEPTH)) : CNT_W'(1);
    assign tx_level = cfg.en ? CNT_W'(level_of(cfg.tx_sel, DEPTH)) : CNT_W'(1);

    uart_char_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst(rst), .clr(rx_clr), .cap(cap),
        .push_valid(rx_in_valid), .push_data(rx_in_data), .push_ready(rx_room),
        .pop_valid(rx_out_valid), .pop_data(rx_out_data), .pop_ready(rx_out_ready),
        .count(rx_count)
    );

    uart_char_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst(rst), .clr(tx_clr), .cap(cap),
        .push_valid(tx_in_valid), .push_data(tx_in_data), .push_ready(tx_in_ready),
        .pop_valid(tx_out_valid), .pop_data(tx_out_data), .pop_ready(tx_out_ready),
        .count(tx_count)
    );

    always_ff @(posedge clk) begin
        if (rst || rx_clr)
            rx_overrun <= 1'b0;
        else if (rx_in_valid && !rx_room)
            rx_overrun <= 1'b1;
    end

    uart_fifo_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst(rst),
        .rx_count(rx_count), .rx_level(rx_level),
        .tx_count(tx_count), .tx_level(tx_level),
        .irq_rx(irq_rx_ready), .irq_tx(irq_tx_empty)
    );

    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_in_valid && !rx_room && !rx_clr) |=> rx_overrun);

    assert_overrun_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        rx_clr |=> (!rx_overrun && !rx_out_valid));

    assert_tx_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        tx_clr |=> !tx_out_valid);

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata[3:1] == 3'b000));

endmodule

// File: tb/tb_uart_fifo_ctrl.sv
module tb_uart_fifo_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_in_valid = 1'b0;
    logic [7:0] rx_in_data = '0;
    logic       rx_out_valid;
    logic [7:0] rx_out_data;
    logic       rx_out_ready = 1'b0;
    logic       tx_in_valid = 1'b0;
    logic [7:0] tx_in_data = '0;
    logic       tx_in_ready;
    logic       tx_out_valid;
    logic [7:0] tx_out_data;
    logic       tx_out_ready = 1'b0;
    logic       rx_overrun, irq_rx_ready, irq_tx_empty;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    uart_fifo_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_ready(rx_out_ready),
        .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
        .rx_overrun(rx_overrun), .irq_rx_ready(irq_rx_ready), .irq_tx_empty(irq_tx_empty)
    );

    // {control word, characters pushed into each FIFO, expected rx irq, expected tx irq}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {8'h01, 6'd7,  1'b0, 1'b1},
        {8'h01, 6'd8,  1'b1, 1'b0},
        {8'h51, 6'd15, 1'b0, 1'b1},
        {8'h51, 6'd16, 1'b1, 1'b0},
        {8'hA1, 6'd23, 1'b0, 1'b1},
        {8'hA1, 6'd24, 1'b1, 1'b0},
        {8'hF1, 6'd27, 1'b0, 1'b1},
        {8'hF1, 6'd28, 1'b1, 1'b0},
        {8'h31, 6'd10, 1'b1, 1'b1},
        {8'hC1, 6'd10, 1'b0, 1'b0},
        {8'h00, 6'd1,  1'b1, 1'b0},
        {8'h00, 6'd0,  1'b0, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push(input int n, input bit do_rx, input bit do_tx, input int base);
        for (int i = 0; i < n; i++) begin
            rx_in_valid = do_rx;
            rx_in_data  = 8'(base + i);
            tx_in_valid = do_tx;
            tx_in_data  = 8'(base + i);
            @(negedge clk);
        end
        rx_in_valid = 1'b0;
        tx_in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic rx_pop(input int exp, input string req);
        chk(req, rx_out_valid, 1);
        chk(req, rx_out_data, exp);
        rx_out_ready = 1'b1;
        @(negedge clk);
        rx_out_ready = 1'b0;
    endtask

    task automatic tx_pop(input int exp, input string req);
        chk(req, tx_out_valid, 1);
        chk(req, tx_out_data, exp);
        tx_out_ready = 1'b1;
        @(negedge clk);
        tx_out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: state after reset
        chk("R1 rdata", reg_rdata, 0);
        chk("R1 irq_rx", irq_rx_ready, 0);
        chk("R1 irq_tx", irq_tx_empty, 1);
        chk("R1 rx_valid", rx_out_valid, 0);
        chk("R1 tx_valid", tx_out_valid, 0);
        chk("R1 overrun", rx_overrun, 0);
        chk("R1 tx_ready", tx_in_ready, 1);

        // Threshold table (R6, R7, R2)
        for (int v = 0; v < NV; v++) begin
            host_write(VEC[v][15:8] | 8'h06);
            push(int'(VEC[v][7:2]), 1'b1, 1'b1, 0);
            @(negedge clk);
            chk("R6 irq_rx table", irq_rx_ready, int'(VEC[v][1]));
            chk("R7 irq_tx table", irq_tx_empty, int'(VEC[v][0]));
        end

        // R5, R3, R4: reserved and reset bits read 0
        host_write(8'hFF);
        chk("R5 R3 R4 readback", reg_rdata, 8'hF1);

        // R8: first-in first-out ordering
        host_write(8'h07);
        push(3, 1'b1, 1'b1, 8'hA0);
        rx_pop(8'hA0, "R8 rx order");
        rx_pop(8'hA1, "R8 rx order");
        rx_pop(8'hA2, "R8 rx order");
        chk("R8 rx drained", rx_out_valid, 0);
        tx_pop(8'hA0, "R8 tx order");
        tx_pop(8'hA1, "R8 tx order");

        // R9: receive overflow drops and flags
        host_write(8'h07);
        push(33, 1'b1, 1'b0, 0);
        chk("R9 overrun", rx_overrun, 1);
        for (int k = 0; k < 32; k++) rx_pop(k, "R9 kept data");
        chk("R9 dropped extra", rx_out_valid, 0);
        chk("R9 sticky", rx_overrun, 1);
        host_write(8'h03);
        chk("R3 overrun cleared", rx_overrun, 0);

        // R10: transmit full refuses
        host_write(8'h05);
        push(32, 1'b0, 1'b1, 8'h40);
        chk("R10 ready low", tx_in_ready, 0);
        push(1, 1'b0, 1'b1, 8'hEE);
        chk("R10 still full", tx_in_ready, 0);
        tx_pop(8'h40, "R10 head unchanged");
        chk("R10 room again", tx_in_ready, 1);
        host_write(8'h05);
        chk("R4 tx emptied", tx_out_valid, 0);

        // R2: holding mode keeps one character
        host_write(8'h06);
        push(2, 1'b1, 1'b1, 8'h11);
        chk("R2 hold overrun", rx_overrun, 1);
        chk("R2 tx hold full", tx_in_ready, 0);
        rx_pop(8'h11, "R2 hold keeps first");
        chk("R2 hold single", rx_out_valid, 0);

        // R11: clear and push in the same cycle
        host_write(8'h07);
        push(2, 1'b1, 1'b1, 8'h30);
        reg_wr = 1'b1;
        reg_wdata = 8'h07;
        rx_in_valid = 1'b1;
        tx_in_valid = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        rx_in_valid = 1'b0;
        tx_in_valid = 1'b0;
        chk("R11 rx empty", rx_out_valid, 0);
        chk("R11 tx empty", tx_out_valid, 0);

        // R12: interrupt rises one cycle after the count reaches the threshold
        host_write(8'h07);
        push(7, 1'b1, 1'b0, 0);
        chk("R12 below", irq_rx_ready, 0);
        rx_in_valid = 1'b1;
        @(negedge clk);
        rx_in_valid = 1'b0;
        chk("R12 not yet", irq_rx_ready, 0);
        @(negedge clk);
        chk("R12 raised", irq_rx_ready, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule